// File: doc/BRIEF.md
# Zero-Crossing Edge Detection Filter

This block turns the digitised output of a motor phase comparator into a clean zero-crossing event for sensorless brushless motor control. The comparator bit is looked at only when a sampling strobe is high. Detection is armed by a demagnetization strobe and disarmed by a commutation strobe. While armed, the block waits for the level that follows the selected transition: a high level for a rising crossing, a low level for a falling one. When it sees that level, it issues one single-clock event pulse and sets a sticky status flag.

Two qualification modes are offered. In level mode, a 4-bit setting N asks for N+1 consecutive samples at the expected level. In edge-protected mode, the sample before the qualifying one must have been at the opposite level, and N plays no part. A sensor-mode bit routes a position sensor bit in place of the comparator and always uses level qualification. A synchronous reset clears every piece of state.

Top module: `zc_edge_detect`

## Requirements
- R1: While `rst` is high and after it falls, `zc_evt` and `zc_flag` are 0 and detection is disarmed. A sample at the expected level produces no event until a demagnetization strobe arrives.
- R2: With `pol_rise`=1 the expected level is 1, a rising crossing. With `pol_rise`=0 the expected level is 0, a falling crossing.
- R3: In level mode (`protect_en`=0, `sensor_mode`=0) with `filt_n`=0, the first armed sample at the expected level fires. No transition is needed.
- R4: In level mode, the event fires on the (`filt_n`+1)-th consecutive armed sample at the expected level. A sample at the other level restarts the count. `filt_n`=15 needs 16 samples.
- R5: In edge-protected mode (`protect_en`=1, `sensor_mode`=0), a sample fires only if it is at the expected level and the previous strobed sample was at the opposite level. `filt_n` is ignored.
- R6: A demagnetization strobe arms detection. It also loads the previous-sample register with the present input level, so a level seen before arming cannot form an edge. A sample strobe in the same cycle as a demagnetization strobe is never tested.
- R7: At most one event occurs per armed window. Firing disarms detection until the next demagnetization strobe.
- R8: A commutation strobe disarms detection without an event, including when a qualifying sample arrives in the same cycle.
- R9: With `sensor_mode`=1, `sens_in` replaces `cmp_in`, `cmp_in` is ignored, and level qualification is used whatever `protect_en` holds.
- R10: `zc_evt` goes high for exactly one clock, in the cycle after the clock edge at which the qualifying strobe was sampled.
- R11: `zc_flag` is set in the same cycle as `zc_evt` and stays set until `flag_clr` is sampled high. A set and a clear in the same cycle leave it set.
- R12: Input levels are taken only on cycles with `smp_stb`=1. Changes between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sampling strobe |
| cmp_in | input | 1 | Phase comparator output |
| sens_in | input | 1 | Position sensor bit, used in sensor mode |
| demag_stb | input | 1 | Demagnetization strobe, arms detection |
| comm_stb | input | 1 | Commutation strobe, disarms detection |
| pol_rise | input | 1 | 1: rising crossing, 0: falling crossing |
| protect_en | input | 1 | 1: edge-protected qualification |
| sensor_mode | input | 1 | 1: use sens_in with level qualification |
| filt_n | input | 4 | Level-mode consecutive sample setting N |
| flag_clr | input | 1 | Write-one-to-clear for the sticky flag |
| zc_evt | output | 1 | Single-clock zero-crossing event |
| zc_flag | output | 1 | Sticky zero-crossing flag |

## Verification
The bench goes after the stale-edge case. There, the input is opposite before arming and already at the expected level at the demagnetization strobe. A design that failed to reload the previous sample on arming would fire at once in edge-protected mode. It also drives a filter run broken by one wrong sample and the N=15 limit: a counter that is not restarted, or that wraps, would fire early. Strobe collisions are covered, with a commutation or demagnetization strobe in the same cycle as a qualifying sample; a wrong priority would emit a stray event. It also covers a flag clear that coincides with a new event, where a wrong priority would lose the event from the flag.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

    localparam int unsigned ZCD_FILT_W = 4;

    typedef enum logic {
        QUAL_LEVEL = 1'b0,
        QUAL_EDGE  = 1'b1
    } qual_mode_e;

    typedef struct packed {
        logic       level;
        logic       expect_lvl;
        qual_mode_e mode;
    } sample_sel_t;

    // Level that must be seen after the selected transition.
    function automatic logic expected_level(input logic pol_rise);
        return pol_rise;
    endfunction

    // Sensor mode always uses level qualification.
    function automatic qual_mode_e pick_mode(input logic protect_en,
                                             input logic sensor_mode);
        return (protect_en && !sensor_mode) ? QUAL_EDGE : QUAL_LEVEL;
    endfunction

endpackage

// File: rtl/zcd_window.sv
module zcd_window (
    input  logic clk,
    input  logic rst,
    input  logic demag_stb,
    input  logic comm_stb,
    input  logic fire,
    output logic win_open,
    output logic arm,
    output logic active
);

    logic open_q;

    // Commutation outranks demagnetization; firing closes the window.
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (comm_stb) begin
            open_q <= 1'b0;
        end else if (demag_stb) begin
            open_q <= 1'b1;
        end else if (fire) begin
            open_q <= 1'b0;
        end
    end

    assign win_open = open_q;
    assign arm      = demag_stb && !comm_stb;
    assign active   = open_q && !comm_stb && !demag_stb;

endmodule

// File: rtl/zcd_qualify.sv
module zcd_qualify
    import zcd_pkg::*;
#(
    parameter int unsigned FILT_W = ZCD_FILT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  sample_sel_t       sel,
    input  logic [FILT_W-1:0] filt_n,
    input  logic              arm,
    input  logic              active,
    output logic              fire,
    output logic              prev_lvl
);

    localparam logic [FILT_W-1:0] CNT_MAX = {FILT_W{1'b1}};

    logic              prev_q;
    logic [FILT_W-1:0] run_q;
    logic              match;
    logic              edge_ok;
    logic              level_ok;

    assign match    = (sel.level == sel.expect_lvl);
    assign edge_ok  = (prev_q != sel.expect_lvl);
    assign level_ok = (run_q == filt_n);

    always_comb begin
        fire = 1'b0;
        if (active && smp_stb && match) begin
            unique case (sel.mode)
                QUAL_EDGE:  fire = edge_ok;
                QUAL_LEVEL: fire = level_ok;
                default:    fire = 1'b0;
            endcase
        end
    end

    // Previous sample: reloaded on arming, otherwise on every strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (arm || smp_stb) begin
            prev_q <= sel.level;
        end
    end

    // Run length of consecutive matching samples inside the window.
    always_ff @(posedge clk) begin
        if (rst || arm || !active) begin
            run_q <= '0;
        end else if (smp_stb) begin
            if (!match || fire) begin
                run_q <= '0;
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign prev_lvl = prev_q;

endmodule

// File: rtl/zcd_event.sv
module zcd_event (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic flag_clr,
    output logic zc_evt,
    output logic zc_flag
);

    logic evt_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= fire;
        end
    end

    // Set outranks clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign zc_evt  = evt_q;
    assign zc_flag = flag_q;

endmodule

// File: rtl/zc_edge_detect.sv
module zc_edge_detect
    import zcd_pkg::*;
#(
    parameter int unsigned FILT_W = ZCD_FILT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic              cmp_in,
    input  logic              sens_in,
    input  logic              demag_stb,
    input  logic              comm_stb,
    input  logic              pol_rise,
    input  logic              protect_en,
    input  logic              sensor_mode,
    input  logic [FILT_W-1:0] filt_n,
    input  logic              flag_clr,
    output logic              zc_evt,
    output logic              zc_flag
);

    sample_sel_t sel;
    logic        win_open;
    logic        arm;
    logic        active;
    logic        fire;
    logic        prev_lvl;

    always_comb begin
        sel.level      = sensor_mode ? sens_in : cmp_in;
        sel.expect_lvl = expected_level(pol_rise);
        sel.mode       = pick_mode(protect_en, sensor_mode);
    end

    zcd_window u_window (
        .clk       (clk),
        .rst       (rst),
        .demag_stb (demag_stb),
        .comm_stb  (comm_stb),
        .fire      (fire),
        .win_open  (win_open),
        .arm       (arm),
        .active    (active)
    );

    zcd_qualify #(.FILT_W(FILT_W)) u_qualify (
        .clk      (clk),
        .rst      (rst),
        .smp_stb  (smp_stb),
        .sel      (sel),
        .filt_n   (filt_n),
        .arm      (arm),
        .active   (active),
        .fire     (fire),
        .prev_lvl (prev_lvl)
    );

    zcd_event u_event (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .flag_clr (flag_clr),
        .zc_evt   (zc_evt),
        .zc_flag  (zc_flag)
    );

endmodule

// File: rtl/zcd_checker.sv
module zcd_checker (
    input logic clk,
    input logic rst,
    input logic smp_stb,
    input logic comm_stb,
    input logic flag_clr,
    input logic pol_rise,
    input logic protect_en,
    input logic sensor_mode,
    input logic win_open,
    input logic prev_lvl,
    input logic zc_evt,
    input logic zc_flag
);

    // R10, R7: never two event cycles in a row
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        zc_evt |=> !zc_evt);

    // R10, R12: an event follows an armed, strobed cycle
    a_r12_evt_from_strobe: assert property (@(posedge clk) disable iff (rst)
        zc_evt |-> ($past(smp_stb) && $past(win_open)));

    // R7: the window is shut once the event is out
    a_r7_window_closed: assert property (@(posedge clk) disable iff (rst)
        zc_evt |-> !win_open);

    // R8: commutation in the prior cycle means no event
    a_r8_comm_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(comm_stb) |-> !zc_evt);

    // R11: flag is set whenever the event is
    a_r11_flag_with_evt: assert property (@(posedge clk) disable iff (rst)
        zc_evt |-> zc_flag);

    // R11: a clear without a new event empties the flag
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_clr) && !zc_evt) |-> !zc_flag);

    // R5: edge-protected events need an opposite previous sample
    a_r5_edge_prev: assert property (@(posedge clk) disable iff (rst)
        (zc_evt && $past(protect_en && !sensor_mode))
            |-> ($past(prev_lvl) != $past(pol_rise)));

endmodule

bind zc_edge_detect zcd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_stb     (smp_stb),
    .comm_stb    (comm_stb),
    .flag_clr    (flag_clr),
    .pol_rise    (pol_rise),
    .protect_en  (protect_en),
    .sensor_mode (sensor_mode),
    .win_open    (win_open),
    .prev_lvl    (prev_lvl),
    .zc_evt      (zc_evt),
    .zc_flag     (zc_flag)
);

// File: tb/zc_edge_detect_tb.sv
module zc_edge_detect_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_stb, cmp_in, sens_in, demag_stb, comm_stb;
    logic       pol_rise, protect_en, sensor_mode, flag_clr;
    logic [3:0] filt_n;
    logic       zc_evt, zc_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    zc_edge_detect u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .cmp_in(cmp_in),
        .sens_in(sens_in), .demag_stb(demag_stb), .comm_stb(comm_stb),
        .pol_rise(pol_rise), .protect_en(protect_en),
        .sensor_mode(sensor_mode), .filt_n(filt_n), .flag_clr(flag_clr),
        .zc_evt(zc_evt), .zc_flag(zc_flag)
    );

    // Vector: pol prot sens | filt[3:0] | demag comm smp | cmp sens | exp_evt
    localparam int NV = 36;
    localparam logic [12:0] VEC [0:NV-1] = '{
        // R3 level, N=0, rising
        13'b100_0000_100_00_0,
        13'b100_0000_001_00_0,
        13'b100_0000_001_10_1,
        13'b100_0000_001_10_0, // R7 closed after event
        // R2 falling polarity, R12 no strobe
        13'b000_0000_100_10_0,
        13'b000_0000_001_10_0,
        13'b000_0000_000_00_0,
        13'b000_0000_001_00_1,
        // R4 N=2 with a break in the run
        13'b100_0010_100_00_0,
        13'b100_0010_001_10_0,
        13'b100_0010_001_10_0,
        13'b100_0010_001_00_0,
        13'b100_0010_001_10_0,
        13'b100_0010_001_10_0,
        13'b100_0010_001_10_1,
        // R5 edge protected, N=5 ignored
        13'b110_0101_100_10_0,
        13'b110_0101_001_10_0,
        13'b110_0101_001_00_0,
        13'b110_0101_001_10_1,
        // R6 stale level before arming, then R8 commutation
        13'b110_0000_001_00_0,
        13'b110_0000_100_10_0,
        13'b110_0000_001_10_0,
        13'b110_0000_010_00_0,
        13'b110_0000_001_00_0,
        13'b110_0000_001_10_0,
        // R8 commutation with a qualifying sample
        13'b100_0000_100_00_0,
        13'b100_0000_011_10_0,
        13'b100_0000_001_10_0,
        // R9 sensor mode, protection and comparator ignored
        13'b111_0000_100_01_0,
        13'b111_0000_001_01_1,
        13'b111_0000_100_10_0,
        13'b111_0000_001_10_0,
        // R3 no transition needed, R6 demag with strobe
        13'b100_0000_100_10_0,
        13'b100_0000_001_10_1,
        13'b100_0000_101_10_0,
        13'b100_0000_001_10_1
    };

    task automatic check(input string req, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        smp_stb = 0; demag_stb = 0; comm_stb = 0; flag_clr = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1; idle(); cmp_in = 0; sens_in = 0;
        pol_rise = 1; protect_en = 0; sensor_mode = 0; filt_n = 0;
        repeat (3) step();
        check("R1", zc_evt, 1'b0, "evt in reset");
        check("R1", zc_flag, 1'b0, "flag in reset");
        rst = 0;
        // R1: matching sample with no arming
        cmp_in = 1; smp_stb = 1; step(); idle();
        check("R1", zc_evt, 1'b0, "evt without arming");
        step();

        for (int i = 0; i < NV; i++) begin
            {pol_rise, protect_en, sensor_mode} = VEC[i][12:10];
            filt_n = VEC[i][9:6];
            {demag_stb, comm_stb, smp_stb} = VEC[i][5:3];
            {cmp_in, sens_in} = VEC[i][2:1];
            step();
            checks++;
            if (zc_evt !== VEC[i][0]) begin
                errors++;
                $display("FAIL vector %0d (table R1..) actual=%0b expected=%0b",
                         i, zc_evt, VEC[i][0]);
            end
        end
        idle(); step();

        // R11: flag sticky after the table, clear empties it
        check("R11", zc_flag, 1'b1, "flag sticky");
        flag_clr = 1; step(); idle();
        check("R11", zc_flag, 1'b0, "flag cleared");

        // R11: set and clear together, R10 one-cycle width
        pol_rise = 1; protect_en = 0; sensor_mode = 0; filt_n = 0;
        cmp_in = 1; demag_stb = 1; step(); idle();
        smp_stb = 1; flag_clr = 1; step(); idle();
        check("R10", zc_evt, 1'b1, "evt after strobe");
        check("R11", zc_flag, 1'b1, "set beats clear");
        step();
        check("R10", zc_evt, 1'b0, "evt one cycle");

        // R4: N=15 needs 16 samples
        filt_n = 4'hF; cmp_in = 0; demag_stb = 1; step(); idle();
        cmp_in = 1;
        for (int k = 0; k < 15; k++) begin
            smp_stb = 1; step(); idle();
            check("R4", zc_evt, 1'b0, "N=15 early sample");
        end
        smp_stb = 1; step(); idle();
        check("R4", zc_evt, 1'b1, "N=15 sixteenth sample");

        // R1: reset mid-window disarms
        filt_n = 0; cmp_in = 0; demag_stb = 1; step(); idle();
        rst = 1; step(); rst = 0;
        cmp_in = 1; smp_stb = 1; step(); idle();
        check("R1", zc_evt, 1'b0, "reset disarms window");
        check("R1", zc_flag, 1'b0, "reset clears flag");

        step();
        finish_run();
    end

endmodule